// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block holds the digital control of a four-channel voltage-output converter. A host shifts 16-bit words in over a three-wire serial link: a frame strobe, a serial clock and a data line. Each complete word selects one channel and lands in that channel's input register. A separate DAC register per channel holds the code that drives the converter. All serial lines are sampled by one system clock, so the serial clock must run well below the system clock rate.

A low-active load strobe copies all four input registers to their DAC registers at once. While the strobe is low, the outputs follow the input registers with no clock edge needed. A low-active clear forces every DAC register to zero at once, and the input registers are left alone. After reset all codes are zero, and they stay zero until a written word is loaded. The shift register's top bit can be driven out for daisy chaining. Per-channel gain flags, per-pair reference buffer flags and a synchronised power-down status are also reported. Resolution is set by `RES_BITS` (8, 10 or 12), and the frame timing is the same for all three.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After reset, every `dac_o` code, `gain_o`, `ref_buf_o`, `sdo_o` and `pd_o` reads zero.
- R2: A word is taken MSB first on falling serial clock edges, starting after a falling frame strobe. Bits 15:14 give the channel, bit 13 is the reference buffer flag, bit 12 is the gain flag and bits 11:0 carry the code left-justified. The 16th bit writes the input register of the addressed channel.
- R3: While the load strobe is high and clear is high, a serial write leaves every `dac_o` code unchanged.
- R4: While `ldac_ni` is low, all four `dac_o` codes equal their input registers with no clock edge needed. After it returns high, the codes keep the loaded values.
- R5: While `clr_ni` is low, every `dac_o` code is zero with no clock edge needed, and it stays zero after release until a load. The input registers keep their contents.
- R6: If the frame strobe rises before the 16th bit, the word is dropped and no input register changes.
- R7: With `daisy_en_i` high, `sdo_o` carries the bit shifted in 16 serial clocks earlier. With it low, `sdo_o` is 0.
- R8: A complete word sets `gain_o[channel]` from bit 12 and `ref_buf_o[channel/2]` from bit 13. Nothing else changes these flags.
- R9: `pd_o` follows `pd_i` after the input synchroniser delay.
- R10: Code bits below the resolution (bits 11-RES_BITS down to 0) are ignored.
- R11: Serial clocks beyond the 16th within one frame cause no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock, data taken on falling edges |
| din_i | input | 1 | Serial data in |
| ldac_ni | input | 1 | Load strobe, active low, transfers all input registers |
| clr_ni | input | 1 | Clear, active low, zeroes all DAC registers |
| daisy_en_i | input | 1 | Enables the serial output |
| pd_i | input | 1 | Power-down request |
| dac_o | output | 4*RES_BITS | Four DAC register codes, channel 0 in the low slice |
| gain_o | output | 4 | Per-channel gain flag, 1 selects double range |
| ref_buf_o | output | 2 | Reference buffer flag per channel pair |
| pd_o | output | 1 | Power-down status |
| sdo_o | output | 1 | Serial output for daisy chaining |

## Verification
The hardest state to reach is a single long frame that carries two words. The bench has to check that the first word's bits come out on the serial output in order while the second word shifts in. It also has to check that only the first word is written. The bench holds the frame strobe low for 32 serial clocks and samples `sdo_o` after each one. It then pulses the load strobe to show that the channel of the second word is unchanged. Clear with its input-register retention and aborted frames are shown the same way, through a later load pulse.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int FRAME_W = 16;
  localparam int NUM_CH  = 4;
  localparam int ADDR_W  = 2;
  localparam int FIELD_W = 12;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic               buf_en;
    logic               gain;
    logic [FIELD_W-1:0] field;
  } frame_t;
endpackage

// File: rtl/quad_dac_sync.sv
module quad_dac_sync #(
  parameter int               W       = 1,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/quad_dac_serial_rx.sv
module quad_dac_serial_rx
  import quad_dac_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sync_ni,
  input  logic   sclk_i,
  input  logic   din_i,
  input  logic   daisy_en_i,
  output logic   frame_vld_o,
  output frame_t frame_o,
  output logic   sdo_o
);
  logic               sync_prev_q, sclk_prev_q;
  logic               active_q, vld_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               sync_fall, sync_rise, sclk_fall;

  assign sync_fall = sync_prev_q & ~sync_ni;
  assign sync_rise = ~sync_prev_q & sync_ni;
  assign sclk_fall = sclk_prev_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b1;
      sclk_prev_q <= 1'b1;
      active_q    <= 1'b0;
      vld_q       <= 1'b0;
      cnt_q       <= '0;
      sr_q        <= '0;
    end else begin
      sync_prev_q <= sync_ni;
      sclk_prev_q <= sclk_i;
      vld_q       <= 1'b0;
      if (sync_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (sync_rise) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (sclk_fall && !sync_ni) begin
        sr_q <= {sr_q[FRAME_W-2:0], din_i};
        // count saturates: bits after the 16th only feed the daisy chain
        if (active_q && cnt_q < CNT_W'(FRAME_W)) begin
          cnt_q <= cnt_q + 1'b1;
          vld_q <= (cnt_q == CNT_W'(FRAME_W - 1));
        end
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = frame_t'(sr_q);
  assign sdo_o       = daisy_en_i & sr_q[FRAME_W-1];

  p_write_at_16_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (cnt_q == CNT_W'(FRAME_W)) && active_q);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W));
  p_single_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/quad_dac_chan_reg.sv
module quad_dac_chan_reg #(
  parameter int RES_BITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_ni,
  input  logic                ldac_ni,
  input  logic                wr_i,
  input  logic [RES_BITS-1:0] code_i,
  output logic [RES_BITS-1:0] dac_o
);
  logic [RES_BITS-1:0] in_q, dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   in_q <= '0;
    else if (wr_i) in_q <= code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni)       dac_q <= '0;
    else if (!clr_ni)  dac_q <= '0;
    else if (!ldac_ni) dac_q <= in_q;
  end

  // strobe and clear act at once; the register catches up on the next edge
  assign dac_o = !clr_ni ? '0 : (!ldac_ni ? in_q : dac_q);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldac_ni && clr_ni) |=> (dac_q == $past(dac_q)) || (dac_q == '0));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ldac_ni && clr_ni) |=> (dac_q == $past(in_q)) || (dac_q == '0));
  p_clr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (dac_q == '0) || !ldac_ni);
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int SYNC_STG = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sync_ni,
  input  logic                            sclk_i,
  input  logic                            din_i,
  input  logic                            ldac_ni,
  input  logic                            clr_ni,
  input  logic                            daisy_en_i,
  input  logic                            pd_i,
  output logic [NUM_CH-1:0][RES_BITS-1:0] dac_o,
  output logic [NUM_CH-1:0]               gain_o,
  output logic [NUM_CH/2-1:0]             ref_buf_o,
  output logic                            pd_o,
  output logic                            sdo_o
);
  localparam int DROP = FIELD_W - RES_BITS;

  logic [3:0]            s_q;
  logic                  frm_vld;
  frame_t                frm;
  logic [RES_BITS-1:0]   code;
  logic [NUM_CH-1:0]     gain_q;
  logic [NUM_CH/2-1:0]   rbuf_q;

  // {pd, din, sclk, sync}; strobe and clock idle high
  quad_dac_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b0011)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pd_i, din_i, sclk_i, sync_ni}),
    .q_o   (s_q)
  );

  quad_dac_serial_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_ni    (s_q[0]),
    .sclk_i     (s_q[1]),
    .din_i      (s_q[2]),
    .daisy_en_i (daisy_en_i),
    .frame_vld_o(frm_vld),
    .frame_o    (frm),
    .sdo_o      (sdo_o)
  );

  assign code = RES_BITS'(frm.field >> DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      rbuf_q <= '0;
    end else if (frm_vld) begin
      gain_q[frm.addr]    <= frm.gain;
      rbuf_q[frm.addr[1]] <= frm.buf_en;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    quad_dac_chan_reg #(.RES_BITS(RES_BITS)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_ni (clr_ni),
      .ldac_ni(ldac_ni),
      .wr_i   (frm_vld && (frm.addr == ADDR_W'(ch))),
      .code_i (code),
      .dac_o  (dac_o[ch])
    );
  end

  assign gain_o    = gain_q;
  assign ref_buf_o = rbuf_q;
  assign pd_o      = s_q[3];

  p_ctrl_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld |=> $stable(gain_q) && $stable(rbuf_q));
endmodule

// File: tb/test_quad_dac_ctrl.sv
module test_quad_dac_ctrl;
  localparam int RES = 10;
  localparam int NT  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic ldac_n = 1'b1, clr_n = 1'b1, daisy = 1'b0, pd = 1'b0;
  logic [3:0][RES-1:0] dac;
  logic [3:0] gain;
  logic [1:0] rbuf;
  logic pd_o, sdo;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [RES-1:0] m_in [4];

  // {addr[1:0], buf, gain, field[11:0]}
  localparam logic [15:0] TBL [NT] = '{
    {2'd0, 1'b1, 1'b0, 12'hABC},
    {2'd1, 1'b0, 1'b1, 12'h003},
    {2'd2, 1'b1, 1'b1, 12'hFFF},
    {2'd3, 1'b0, 1'b0, 12'h801},
    {2'd1, 1'b1, 1'b1, 12'h556},
    {2'd2, 1'b0, 1'b0, 12'h004}
  };

  always #2.5 clk = ~clk;

  quad_dac_ctrl #(.RES_BITS(RES)) i_quad_dac_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .sclk_i(sclk), .din_i(din),
    .ldac_ni(ldac_n), .clr_ni(clr_n), .daisy_en_i(daisy), .pd_i(pd),
    .dac_o(dac), .gain_o(gain), .ref_buf_o(rbuf), .pd_o(pd_o), .sdo_o(sdo)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    din = b;  wclk(4);
    sclk = 1'b0; wclk(4);
    sclk = 1'b1;
  endtask

  task automatic send(logic [15:0] w, int nbits);
    sync_n = 1'b0; wclk(4);
    for (int i = 15; i > 15 - nbits; i--) shift_bit(w[i]);
    wclk(4); sync_n = 1'b1; wclk(8);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0; #1;
    for (int c = 0; c < 4; c++) chk("R4 immediate load", dac[c], m_in[c]);
    wclk(3); ldac_n = 1'b1; wclk(3);
    for (int c = 0; c < 4; c++) chk("R4 held after load", dac[c], m_in[c]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) m_in[c] = '0;
    wclk(4); rst_n = 1'b1; wclk(4);
    // R1 reset state
    for (int c = 0; c < 4; c++) chk("R1 dac zero", dac[c], 0);
    chk("R1 gain", gain, 0); chk("R1 ref_buf", rbuf, 0);
    chk("R1 sdo", sdo, 0);   chk("R1 pd", pd_o, 0);

    // vector walk: R2, R3, R8, R10
    for (int t = 0; t < NT; t++) begin
      logic [15:0] w;
      logic [RES-1:0] prev;
      int a;
      w = TBL[t]; a = w[15:14]; prev = dac[a];
      send(w, 16);
      chk("R3 no change before load", dac[a], prev);
      chk("R8 gain flag", gain[a], w[12]);
      chk("R8 ref_buf flag", rbuf[a/2], w[13]);
      m_in[a] = RES'(w[11:0] >> (12 - RES));  // R10 low bits dropped
      pulse_ldac();
      chk("R2 R10 channel code", dac[a], m_in[a]);
    end

    // R5 clear
    clr_n = 1'b0; #1;
    for (int c = 0; c < 4; c++) chk("R5 clear immediate", dac[c], 0);
    wclk(3); clr_n = 1'b1; wclk(3);
    for (int c = 0; c < 4; c++) chk("R5 zero after release", dac[c], 0);
    pulse_ldac();  // R5 input registers retained

    // R6 aborted frame
    send({2'd3, 1'b1, 1'b1, 12'h3C0}, 10);
    chk("R8 flags untouched by abort", gain[3], 0);
    pulse_ldac();
    chk("R6 abort leaves ch3", dac[3], m_in[3]);

    // R7 / R11 daisy chain with two words in one frame
    begin
      logic [15:0] wa, wb;
      wa = {2'd0, 1'b0, 1'b1, 12'h5A4};
      wb = {2'd2, 1'b1, 1'b0, 12'h123};
      daisy = 1'b1;
      sync_n = 1'b0; wclk(4);
      for (int i = 15; i >= 0; i--) shift_bit(wa[i]);
      chk("R7 sdo first bit out", sdo, wa[15]);
      for (int j = 0; j < 16; j++) begin
        shift_bit(wb[15 - j]);
        if (j < 15) chk("R7 sdo delayed by 16", sdo, wa[14 - j]);
      end
      wclk(4); sync_n = 1'b1; wclk(8);
      m_in[0] = RES'(wa[11:0] >> (12 - RES));
      chk("R11 no second write flag", rbuf[1], 0);
      pulse_ldac();
      chk("R11 ch2 untouched", dac[2], m_in[2]);
      chk("R7 sdo enabled shows msb", sdo, wb[15]);
      daisy = 1'b0; #1;
      chk("R7 sdo off when disabled", sdo, 0);
    end

    // R9 power-down
    pd = 1'b1; wclk(4); chk("R9 pd set", pd_o, 1);
    pd = 1'b0; wclk(4); chk("R9 pd clear", pd_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule